// File: doc/BRIEF.md
# Rearrangeable Permutation Network

The block steers N data words (N a power of two) from its inputs to its outputs along a statically configured permutation. It is a multistage fabric of 2x2 exchange elements. Each element either passes its two words straight through or swaps them. An outer input column and an outer output column of elements surround two half-size networks of the same kind, and that nesting repeats down to single elements. The result is 2·log2(N)−1 columns of N/2 elements. The fabric can realize every one of the N! permutations, and its crosspoint count grows as N·log N rather than N².

Software or a host controller computes the element settings off-chip. It writes them 32 bits at a time into a staging register through an address/data port. An apply strobe then moves the whole staged vector into the active register that steers the fabric, so the routing never changes part-way through a reload. The data path is combinational by default. A parameter adds one output register stage.

Top module: `benes_net`

## Requirements
- R1: After reset every element is straight, so output word i equals input word i for every i.
- R2: Element e of column s (0 ≤ s < 2n−1, n = log2 N) is steered by configuration bit s·(N/2)+e. Its pair distance is d = 2^(n−1−s) for s < n and 2^(s−n+1) otherwise. It joins lines lo = (e div d)·2d + (e mod d) and lo+d, and all lines keep their index between columns. A bit value of 1 swaps the two words and 0 passes them straight.
- R3: For any permutation perm of the N inputs there is a configuration with which output perm(j) carries input j. Equivalently, output i carries input perm⁻¹(i).
- R4: A write with cfg_we_i high loads cfg_wdata_i into staging word cfg_addr_i. Configuration bit k lives in bit k mod 32 of word k div 32.
- R5: Staged writes leave the routing unchanged. A high cfg_apply_i copies the staged vector into the active vector at that clock edge, and the new routing is seen from the next cycle on.
- R6: A write to an address at or beyond ceil((2n−1)·N/2 / 32) is ignored and changes neither staged nor active routing.
- R7: With OUT_REG = 0, data_o follows data_i in the same cycle. With OUT_REG = 1, data_o is cleared by reset and shows the routed data_i one clock edge later.
- R8: When a write and an apply fall on the same edge, the apply copies the staged contents as they stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Staging word write enable |
| cfg_addr_i | input | CFG_AW | Staging word address |
| cfg_wdata_i | input | 32 | Staging word data |
| cfg_apply_i | input | 1 | Copy staged vector into the active vector |
| data_i | input | N_PORTS·DATA_W | Input words, word j in bits j·DATA_W upward |
| data_o | output | N_PORTS·DATA_W | Permuted output words |

## Verification
The bench sets each configuration bit alone in turn. A fabric with a miswired pair distance, or a bit that steers the wrong element, would then put some word on the wrong line. It routes many random permutations plus the identity and the reversal for N = 8 and N = 16, with settings from a looping solver. This catches a wrong column count or a broken recursion, either of which would leave some permutations unreachable. Timing checks cover the case where routing changes before apply, a write to an out-of-range address that lands in some word anyway, and a same-edge write and apply that picks up the new word. They also cover the latency of the output register, which would show the new data a cycle early or late.

// File: rtl/benes_pkg.sv
`timescale 1ns/1ps
package benes_pkg;
  localparam int unsigned CFG_WORD_W = 32;

  // pair distance of column s in a fabric with log_n address bits
  function automatic int unsigned stage_dist(int unsigned s, int unsigned log_n);
    if (s < log_n) return 1 << (log_n - 1 - s);
    return 1 << (s - log_n + 1);
  endfunction

  // lower line index of element e for pair distance d
  function automatic int unsigned pair_lo(int unsigned e, int unsigned d);
    return (e / d) * 2 * d + (e % d);
  endfunction
endpackage

// File: rtl/benes_switch2.sv
`timescale 1ns/1ps
module benes_switch2 #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  assign a_o = sel_i ? b_i : a_i;
  assign b_o = sel_i ? a_i : b_i;
endmodule

// File: rtl/benes_fabric.sv
`timescale 1ns/1ps
module benes_fabric
  import benes_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned DATA_W  = 16
) (
  input  logic [(2*$clog2(N_PORTS)-1)*(N_PORTS/2)-1:0] cfg_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0]               data_i,
  output logic [N_PORTS-1:0][DATA_W-1:0]               data_o
);
  localparam int unsigned LOG_N    = $clog2(N_PORTS);
  localparam int unsigned N_STAGES = 2 * LOG_N - 1;
  localparam int unsigned HALF     = N_PORTS / 2;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    logic [N_PORTS-1:0][DATA_W-1:0] s_in;
    logic [N_PORTS-1:0][DATA_W-1:0] s_out;
    if (s == 0) begin : g_first
      assign s_in = data_i;
    end else begin : g_next
      assign s_in = g_stage[s-1].s_out;
    end
    for (genvar e = 0; e < HALF; e++) begin : g_elem
      localparam int unsigned D  = stage_dist(s, LOG_N);
      localparam int unsigned LO = pair_lo(e, D);
      benes_switch2 #(.DATA_W(DATA_W)) u_sw (
        .sel_i (cfg_i[s*HALF+e]),
        .a_i   (s_in[LO]),
        .b_i   (s_in[LO+D]),
        .a_o   (s_out[LO]),
        .b_o   (s_out[LO+D])
      );
    end
  end

  assign data_o = g_stage[N_STAGES-1].s_out;
endmodule

// File: rtl/benes_cfg_regs.sv
`timescale 1ns/1ps
module benes_cfg_regs
  import benes_pkg::*;
#(
  parameter int unsigned N_ELEMS = 20,
  parameter int unsigned CFG_AW  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [CFG_AW-1:0]     addr_i,
  input  logic [CFG_WORD_W-1:0] wdata_i,
  input  logic                  apply_i,
  output logic [N_ELEMS-1:0]    cfg_o
);
  localparam int unsigned N_WORDS = (N_ELEMS + CFG_WORD_W - 1) / CFG_WORD_W;

  logic [CFG_WORD_W-1:0]         stage_q [N_WORDS];
  logic [N_WORDS*CFG_WORD_W-1:0] stage_flat;
  logic [N_ELEMS-1:0]            active_q;
  logic                          unused_pad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < N_WORDS; w++) stage_q[w] <= '0;
    end else begin
      for (int w = 0; w < N_WORDS; w++)
        if (we_i && (32'(addr_i) == w)) stage_q[w] <= wdata_i;
    end
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_flat
    assign stage_flat[w*CFG_WORD_W +: CFG_WORD_W] = stage_q[w];
  end
  assign unused_pad = ^stage_flat;

  // apply samples staging before any write on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= '0;
    else if (apply_i) active_q <= stage_flat[N_ELEMS-1:0];
  end

  assign cfg_o = active_q;

  p_stage_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(stage_flat));
  p_apply_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> active_q == $past(stage_flat[N_ELEMS-1:0]));
  p_active_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(active_q));
  p_bad_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && 32'(addr_i) >= N_WORDS) |=> $stable(stage_flat));
endmodule

// File: rtl/benes_net.sv
`timescale 1ns/1ps
module benes_net
  import benes_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CFG_AW  = 4,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [CFG_AW-1:0]           cfg_addr_i,
  input  logic [31:0]                 cfg_wdata_i,
  input  logic                        cfg_apply_i,
  input  logic [N_PORTS*DATA_W-1:0]   data_i,
  output logic [N_PORTS*DATA_W-1:0]   data_o
);
  localparam int unsigned LOG_N   = $clog2(N_PORTS);
  localparam int unsigned N_ELEMS = (2 * LOG_N - 1) * (N_PORTS / 2);

  logic [N_ELEMS-1:0]             cfg_act;
  logic [N_PORTS-1:0][DATA_W-1:0] fab_in;
  logic [N_PORTS-1:0][DATA_W-1:0] fab_out;
  logic [DATA_W-1:0]              x_in;
  logic [DATA_W-1:0]              x_out;

  benes_cfg_regs #(.N_ELEMS(N_ELEMS), .CFG_AW(CFG_AW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .apply_i (cfg_apply_i),
    .cfg_o   (cfg_act)
  );

  assign fab_in = data_i;

  benes_fabric #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_fabric (
    .cfg_i  (cfg_act),
    .data_i (fab_in),
    .data_o (fab_out)
  );

  if (OUT_REG) begin : g_oreg
    logic [N_PORTS*DATA_W-1:0] out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q <= '0;
      else         out_q <= fab_out;
    end
    assign data_o = out_q;

    p_out_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> data_o == $past(fab_out));
  end else begin : g_comb
    assign data_o = fab_out;
  end

  // a permutation keeps the XOR of all words
  always_comb begin
    x_in  = '0;
    x_out = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      x_in  ^= fab_in[i];
      x_out ^= fab_out[i];
    end
  end

  p_word_conserve_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_in == x_out);
endmodule

// File: tb/benes_net_tb_top.sv
`timescale 1ns/1ps
module benes_net_tb_core #(
  parameter int unsigned N    = 8,
  parameter bit          OREG = 1'b0
) (
  input  logic clk,
  output logic done,
  output int   n_chk,
  output int   n_err
);
  localparam int unsigned LOG_N = $clog2(N);
  localparam int unsigned S     = 2 * LOG_N - 1;
  localparam int unsigned H     = N / 2;
  localparam int unsigned NE    = S * H;
  localparam int unsigned NW    = (NE + 31) / 32;
  localparam int unsigned W     = 16;

  logic              rst_n, we, apply;
  logic [3:0]        addr;
  logic [31:0]       wdata;
  logic [N-1:0][W-1:0] din_a, dout_a, exp_a;
  logic [N*W-1:0]    din, dout;
  logic [NW*32-1:0]  cfgv, cfgb;
  int perm [N];
  int pc [N];
  int npc [N];
  int side [N];

  assign din    = din_a;
  assign dout_a = dout;

  benes_net #(.N_PORTS(N), .DATA_W(W), .CFG_AW(4), .OUT_REG(OREG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_apply_i(apply), .data_i(din), .data_o(dout)
  );

  task automatic check(input string tag, input logic [N-1:0][W-1:0] exp);
    n_chk++;
    if (dout_a !== exp) begin
      n_err++;
      $display("FAIL %s N=%0d: got %h expected %h", tag, N, dout_a, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic app();
    @(negedge clk); apply = 1'b1;
    @(negedge clk); apply = 1'b0;
  endtask

  task automatic load(input logic [NW*32-1:0] v);
    for (int w = 0; w < NW; w++) wr(w, v[w*32 +: 32]);
  endtask

  task automatic new_data();
    for (int j = 0; j < N; j++) din_a[j] = {8'($urandom), 8'(j)};
  endtask

  // network model from the R2 wiring rule
  function automatic logic [N-1:0][W-1:0] model(input logic [NW*32-1:0] v,
                                                input logic [N-1:0][W-1:0] x);
    logic [N-1:0][W-1:0] l;
    logic [W-1:0] t;
    l = x;
    for (int s = 0; s < S; s++) begin
      int d;
      d = (s < LOG_N) ? (1 << (LOG_N - 1 - s)) : (1 << (s - LOG_N + 1));
      for (int e = 0; e < H; e++) begin
        int lo;
        lo = (e / d) * 2 * d + (e % d);
        if (v[s*H + e]) begin t = l[lo]; l[lo] = l[lo+d]; l[lo+d] = t; end
      end
    end
    return l;
  endfunction

  function automatic logic [N-1:0][W-1:0] perm_exp(input logic [N-1:0][W-1:0] x);
    logic [N-1:0][W-1:0] r;
    r = '0;
    for (int j = 0; j < N; j++) r[perm[j]] = x[j];
    return r;
  endfunction

  // looping algorithm: settings so that input j reaches output perm[j]
  task automatic route();
    cfgv = '0;
    for (int i = 0; i < N; i++) pc[i] = perm[i];
    for (int k = 0; k < LOG_N - 1; k++) begin
      int sz, h;
      sz = N >> k; h = sz / 2;
      for (int b = 0; b < N; b += sz) begin
        for (int i = 0; i < sz; i++) side[b+i] = -1;
        for (int a0 = 0; a0 < h; a0++) begin
          if (side[b+a0] == -1) begin
            int i;
            bit go;
            i = a0; go = 1'b1;
            while (go) begin
              int ip, o, op, jj;
              side[b+i] = 0;
              ip = (i < h) ? i + h : i - h;
              side[b+ip] = 1;
              o  = pc[b+ip];
              op = (o < h) ? o + h : o - h;
              jj = 0;
              for (int t = 0; t < sz; t++) if (pc[b+t] == op) jj = t;
              if (side[b+jj] != -1) go = 1'b0;
              else i = jj;
            end
          end
        end
        for (int i = 0; i < sz; i++) begin
          int o;
          o = pc[b+i];
          if (i < h && side[b+i] == 1) cfgv[k*H + b/2 + i] = 1'b1;
          if (o < h && side[b+i] == 1) cfgv[(S-1-k)*H + b/2 + o] = 1'b1;
          if (side[b+i] == 0) npc[b + i%h] = o % h;
          else                npc[b + h + i%h] = o % h;
        end
      end
      for (int i = 0; i < N; i++) pc[i] = npc[i];
    end
    for (int b = 0; b < N; b += 2)
      if (pc[b] == 1) cfgv[(LOG_N-1)*H + b/2] = 1'b1;
  endtask

  task automatic rand_perm();
    for (int i = 0; i < N; i++) perm[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int j, t;
      j = int'($urandom_range(i, 0));
      t = perm[i]; perm[i] = perm[j]; perm[j] = t;
    end
  endtask

  initial begin
    logic [N-1:0][W-1:0] prev;
    done = 1'b0; n_chk = 0; n_err = 0;
    rst_n = 1'b0; we = 1'b0; apply = 1'b0; addr = '0; wdata = '0;
    new_data();
    repeat (3) @(negedge clk);
    if (OREG) check("R7 reset clears output", '0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 identity after reset", din_a);

    // R7: same-cycle vs one-edge latency
    prev = din_a;
    new_data();
    #1;
    check("R7 latency", OREG ? prev : din_a);
    @(negedge clk);
    check("R7 settled", din_a);

    // R2 / R4: each bit alone
    for (int k = 0; k < NE; k++) begin
      cfgv = '0; cfgv[k] = 1'b1;
      load(cfgv); app();
      new_data();
      @(negedge clk);
      check("R2 R4 single element", model(cfgv, din_a));
    end

    // R3: identity, reversal, random permutations
    for (int n = 0; n < 42; n++) begin
      if (n == 0)      for (int i = 0; i < N; i++) perm[i] = i;
      else if (n == 1) for (int i = 0; i < N; i++) perm[i] = N - 1 - i;
      else rand_perm();
      route(); load(cfgv); app();
      new_data();
      @(negedge clk);
      check("R3 permutation", perm_exp(din_a));
    end

    // R5: staged writes do not alter routing before apply
    rand_perm(); route(); load(cfgv); app();
    exp_a = perm_exp(din_a);
    @(negedge clk);
    check("R5 baseline", exp_a);
    rand_perm(); route(); load(cfgv);
    @(negedge clk);
    check("R5 held before apply", exp_a);
    app();
    @(negedge clk);
    check("R5 new routing after apply", perm_exp(din_a));
    exp_a = perm_exp(din_a);

    // R6: writes beyond the last word are ignored
    wr(NW, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    app();
    @(negedge clk);
    check("R6 out-of-range write ignored", exp_a);

    // R8: write and apply on the same edge
    cfgb = cfgv;
    rand_perm(); route();
    for (int w = 1; w < NW; w++) wr(w, cfgv[w*32 +: 32]);
    @(negedge clk); we = 1'b1; addr = '0; wdata = cfgv[31:0]; apply = 1'b1;
    @(negedge clk); we = 1'b0; apply = 1'b0;
    begin
      logic [NW*32-1:0] mix;
      mix = cfgv; mix[31:0] = cfgb[31:0];
      @(negedge clk);
      check("R8 apply takes pre-write word", model(mix, din_a));
    end
    app();
    @(negedge clk);
    check("R8 follow-up apply", perm_exp(din_a));

    done = 1'b1;
  end
endmodule

module benes_net_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic d8, d16;
  int c8, e8, c16, e16;

  benes_net_tb_core #(.N(8),  .OREG(1'b0)) u_n8  (.clk(clk), .done(d8),  .n_chk(c8),  .n_err(e8));
  benes_net_tb_core #(.N(16), .OREG(1'b1)) u_n16 (.clk(clk), .done(d16), .n_chk(c16), .n_err(e16));

  initial begin
    int cyc;
    int chks, errs;
    cyc = 0;
    @(posedge clk);
    while (!(d8 === 1'b1 && d16 === 1'b1) && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    chks = c8 + c16;
    errs = e8 + e16;
    if (!(d8 === 1'b1 && d16 === 1'b1)) begin
      chks++; errs++;
      $display("FAIL watchdog: run did not complete, got done=%b%b expected 11", d8, d16);
    end
    $display("Simulation finished: %0d checks, %0d errors", chks, errs);
    $finish;
  end
endmodule